// File: doc/BRIEF.md
# Flash Operating-Mode Control Register

This block is the mode register that sits in front of an on-chip flash array. Software reaches it through a simple select/write-strobe bus. It uses the register to step the array from plain read into program, erase, program-verify or erase-verify. Each writable bit belongs to a layer. A write to a bit lands only when the hardware write-enable pin and that bit's lower layers are already set. This means a program or erase can only be started by a deliberate sequence of separate writes.

The top bit reads back the level of the write-enable pin, and software cannot write it. When the pin is low, the array is hardware-protected: every writable bit clears and the mode outputs fall back to read at once. Reset, hardware standby and software standby all reinitialise the register. While the flash is disabled, the register reads as zero and ignores writes, but it keeps its contents.

A small state machine turns the register contents into a mode code for the flash controller, one clock after the register changes. It has eight states:
- READ
- ARMED (software enable set, nothing else active)
- PROG_SETUP
- PROGRAM
- ERASE_SETUP
- ERASE
- PROG_VERIFY
- ERASE_VERIFY

On every clock it moves to the state that the register decodes to, by the priority given in R8. For example:
- READ goes to ARMED when the software enable is set.
- ARMED goes to PROG_SETUP, then to PROGRAM.
- ARMED goes to ERASE_SETUP, then to ERASE.
- ARMED goes to either verify state.
- Every state goes back to READ when the pin falls, the flash is disabled, a standby clears the register, or the software enable is cleared.

Top module: `flash_mode_ctl`

## Requirements
- R1: After reset the register reads {pin, 7'b0}, which is 0x80 with the pin high and 0x00 with it low. Bit 7 always reads the pin level, and writes to bit 7 are ignored.
- R2: When hw_standby or sw_standby is high at a clock edge, bits 6..0 become 0 at that edge. This takes priority over any write in the same cycle.
- R3: While flash_en is low, bus_rdata is 0x00 and writes are discarded. The stored bits reappear unchanged once flash_en returns high. bus_rdata is also 0x00 whenever bus_sel is low.
- R4: Bit 6 (software enable) accepts a write whenever the pin is high.
- R5: Bits 5 (erase setup), 4 (program setup), 3 (erase verify) and 2 (program verify) accept a write only when the pin is high and bit 6 is already 1 before that write.
- R6: Bit 1 (erase go) accepts a write only when the pin is high and bits 6 and 5 are already 1. Bit 0 (program go) accepts a write only when the pin is high and bits 6 and 4 are already 1. A blocked bit keeps its value while the permitted bits of the same write update.
- R7: While the pin is low, mode_o reads READ and prog_en_o and erase_en_o read 0 in the same cycle. Bits 6..0 clear at the next edge.
- R8: mode_o shows, one clock after the register changes, this decode:
  - READ = 0 if the pin, flash_en or bit 6 is low.
  - Otherwise, by priority:
    - PROGRAM = 3 if bits 4 and 0 are both set.
    - ERASE = 5 if bits 5 and 1 are both set.
    - PROG_SETUP = 2 if bit 4 is set.
    - ERASE_SETUP = 4 if bit 5 is set.
    - PROG_VERIFY = 6 if bit 2 is set.
    - ERASE_VERIFY = 7 if bit 3 is set.
    - ARMED = 1 otherwise.
- R9: prog_en_o is 1 exactly when mode_o is PROGRAM, and erase_en_o is 1 exactly when mode_o is ERASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_wen_pin | input | 1 | Hardware write-enable pin level (low = protected) |
| hw_standby | input | 1 | Hardware standby entry, clears the register |
| sw_standby | input | 1 | Software standby entry, clears the register |
| flash_en | input | 1 | On-chip flash enabled |
| bus_sel | input | 1 | Register selected on the bus |
| bus_wr | input | 1 | Write strobe (qualified by bus_sel) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| mode_o | output | 3 | Operating mode code (R8) |
| prog_en_o | output | 1 | Program mode active |
| erase_en_o | output | 1 | Erase mode active |

## Verification
The assertions assume that the pin, the standby lines and flash_en are synchronous to clk and change only between edges. They also take the bus write strobe as meaningful only while bus_sel is high. The bench drives every input on the falling edge and holds the pin and flash_en steady through each sweep, so that each write sees a settled gating condition. It changes those levels only in the dedicated protection, standby and disable scenarios. There it samples the combinational outputs after a short settle delay and the registered mode one edge later.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;

    localparam int REG_W  = 8;
    localparam int WBITS  = REG_W - 1;
    localparam int MODE_W = 3;

    localparam int BIT_PRG_GO    = 0;
    localparam int BIT_ERS_GO    = 1;
    localparam int BIT_PRG_VFY   = 2;
    localparam int BIT_ERS_VFY   = 3;
    localparam int BIT_PRG_SETUP = 4;
    localparam int BIT_ERS_SETUP = 5;
    localparam int BIT_SW_EN     = 6;
    localparam int BIT_HW_EN     = 7;

    typedef enum logic [MODE_W-1:0] {
        M_READ         = 3'd0,
        M_ARMED        = 3'd1,
        M_PROG_SETUP   = 3'd2,
        M_PROGRAM      = 3'd3,
        M_ERASE_SETUP  = 3'd4,
        M_ERASE        = 3'd5,
        M_PROG_VERIFY  = 3'd6,
        M_ERASE_VERIFY = 3'd7
    } fmode_e;

    typedef enum logic [1:0] {
        GATE_PIN,
        GATE_SWEN,
        GATE_ERS,
        GATE_PRG
    } gate_e;

    function automatic gate_e gate_of(input int b);
        if (b == BIT_SW_EN)       return GATE_PIN;
        else if (b == BIT_ERS_GO) return GATE_ERS;
        else if (b == BIT_PRG_GO) return GATE_PRG;
        else                      return GATE_SWEN;
    endfunction

endpackage

// File: rtl/fmc_wr_gate.sv
module fmc_wr_gate
    import flash_mode_pkg::*;
#(
    parameter int NBITS = WBITS
) (
    input  logic             pin_i,
    input  logic             flash_en_i,
    input  logic             wr_i,
    input  logic             swen_i,
    input  logic             ers_setup_i,
    input  logic             prg_setup_i,
    output logic [NBITS-1:0] wen_o
);

    logic base_ok;
    assign base_ok = wr_i & flash_en_i & pin_i;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        localparam gate_e G = gate_of(i);
        if (G == GATE_PIN) begin : g_pin
            assign wen_o[i] = base_ok;
        end else if (G == GATE_ERS) begin : g_ers
            assign wen_o[i] = base_ok & swen_i & ers_setup_i;
        end else if (G == GATE_PRG) begin : g_prg
            assign wen_o[i] = base_ok & swen_i & prg_setup_i;
        end else begin : g_swen
            assign wen_o[i] = base_ok & swen_i;
        end
    end

endmodule

// File: rtl/fmc_regbits.sv
module fmc_regbits
    import flash_mode_pkg::*;
#(
    parameter int NBITS = WBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             flash_en_i,
    input  logic             wr_i,
    input  logic             hw_standby_i,
    input  logic             sw_standby_i,
    input  logic [NBITS-1:0] wen_i,
    input  logic [NBITS-1:0] wdata_i,
    output logic [NBITS-1:0] bits_q
);

    logic             clear_now;
    logic [NBITS-1:0] bits_d;

    assign clear_now = ~pin_i | hw_standby_i | sw_standby_i;

    for (genvar i = 0; i < NBITS; i++) begin : g_next
        assign bits_d[i] = wen_i[i] ? wdata_i[i] : bits_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (clear_now) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    // R7: protection pin low wipes every writable bit
    p_pin_low_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_i |=> (bits_q == '0));

    // R2: either standby input clears the register
    p_standby_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_standby_i | sw_standby_i) |=> (bits_q == '0));

    // R3: writes while flash is disabled leave contents untouched
    p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i & !flash_en_i & pin_i & !hw_standby_i & !sw_standby_i) |=> $stable(bits_q));

    // R5: setup and verify bits rise only with software enable already set
    p_ctrl_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bits_q[BIT_ERS_SETUP]) | $rose(bits_q[BIT_PRG_SETUP]) |
         $rose(bits_q[BIT_ERS_VFY])   | $rose(bits_q[BIT_PRG_VFY]))
        |-> $past(bits_q[BIT_SW_EN]));

    // R6: erase go rises only after erase setup
    p_erase_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bits_q[BIT_ERS_GO]) |-> $past(bits_q[BIT_SW_EN] & bits_q[BIT_ERS_SETUP]));

    // R6: program go rises only after program setup
    p_prog_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bits_q[BIT_PRG_GO]) |-> $past(bits_q[BIT_SW_EN] & bits_q[BIT_PRG_SETUP]));

endmodule

// File: rtl/fmc_mode_fsm.sv
module fmc_mode_fsm
    import flash_mode_pkg::*;
#(
    parameter int NBITS = WBITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic              flash_en_i,
    input  logic [NBITS-1:0]  bits_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              prog_en_o,
    output logic              erase_en_o
);

    fmode_e state_q;
    fmode_e state_d;

    // Next state: the state the register contents decode to, by priority
    always_comb begin
        if (!pin_i || !flash_en_i || !bits_i[BIT_SW_EN]) begin
            state_d = M_READ;
        end else if (bits_i[BIT_PRG_SETUP] && bits_i[BIT_PRG_GO]) begin
            state_d = M_PROGRAM;
        end else if (bits_i[BIT_ERS_SETUP] && bits_i[BIT_ERS_GO]) begin
            state_d = M_ERASE;
        end else if (bits_i[BIT_PRG_SETUP]) begin
            state_d = M_PROG_SETUP;
        end else if (bits_i[BIT_ERS_SETUP]) begin
            state_d = M_ERASE_SETUP;
        end else if (bits_i[BIT_PRG_VFY]) begin
            state_d = M_PROG_VERIFY;
        end else if (bits_i[BIT_ERS_VFY]) begin
            state_d = M_ERASE_VERIFY;
        end else begin
            state_d = M_ARMED;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_READ;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        mode_o     = state_q;
        prog_en_o  = 1'b0;
        erase_en_o = 1'b0;
        unique case (state_q)
            M_PROGRAM: prog_en_o  = 1'b1;
            M_ERASE:   erase_en_o = 1'b1;
            M_READ, M_ARMED, M_PROG_SETUP, M_ERASE_SETUP,
            M_PROG_VERIFY, M_ERASE_VERIFY: ;
            default: ;
        endcase
        if (!pin_i) begin
            mode_o     = M_READ;
            prog_en_o  = 1'b0;
            erase_en_o = 1'b0;
        end
    end

    // R8: program state is only held while the register carried both program bits
    p_prog_requires_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_PROGRAM) |-> $past(bits_i[BIT_PRG_SETUP] & bits_i[BIT_PRG_GO] & bits_i[BIT_SW_EN]));

    // R9: never both pulse enables at once
    p_enables_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en_o & erase_en_o));

endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
    import flash_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_wen_pin,
    input  logic              hw_standby,
    input  logic              sw_standby,
    input  logic              flash_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [MODE_W-1:0] mode_o,
    output logic              prog_en_o,
    output logic              erase_en_o
);

    logic             wr_strobe;
    logic [WBITS-1:0] wen;
    logic [WBITS-1:0] bits_q;
    logic             unused_hw_bit;

    assign wr_strobe     = bus_sel & bus_wr;
    assign unused_hw_bit = bus_wdata[BIT_HW_EN];

    fmc_wr_gate #(.NBITS(WBITS)) u_gate (
        .pin_i       (hw_wen_pin),
        .flash_en_i  (flash_en),
        .wr_i        (wr_strobe),
        .swen_i      (bits_q[BIT_SW_EN]),
        .ers_setup_i (bits_q[BIT_ERS_SETUP]),
        .prg_setup_i (bits_q[BIT_PRG_SETUP]),
        .wen_o       (wen)
    );

    fmc_regbits #(.NBITS(WBITS)) u_bits (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (hw_wen_pin),
        .flash_en_i   (flash_en),
        .wr_i         (wr_strobe),
        .hw_standby_i (hw_standby),
        .sw_standby_i (sw_standby),
        .wen_i        (wen),
        .wdata_i      (bus_wdata[WBITS-1:0]),
        .bits_q       (bits_q)
    );

    fmc_mode_fsm #(.NBITS(WBITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (hw_wen_pin),
        .flash_en_i (flash_en),
        .bits_i     (bits_q),
        .mode_o     (mode_o),
        .prog_en_o  (prog_en_o),
        .erase_en_o (erase_en_o)
    );

    assign bus_rdata = (bus_sel & flash_en) ? {hw_wen_pin, bits_q} : '0;

    // R3: disabled flash never exposes register contents
    p_disabled_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_en |-> (bus_rdata == '0));

endmodule

// File: tb/flash_mode_ctl_bench.sv
`timescale 1ns/1ps
module flash_mode_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_wen_pin = 1'b1;
    logic       hw_standby = 1'b0;
    logic       sw_standby = 1'b0;
    logic       flash_en = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] mode_o;
    logic       prog_en_o;
    logic       erase_en_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [6:0] model = '0;

    always #4 clk = ~clk;

    flash_mode_ctl u_flash_mode_ctl (
        .clk(clk), .rst_n(rst_n), .hw_wen_pin(hw_wen_pin),
        .hw_standby(hw_standby), .sw_standby(sw_standby), .flash_en(flash_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mode_o(mode_o),
        .prog_en_o(prog_en_o), .erase_en_o(erase_en_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // pin=1, flash_en=1 write rule from R4..R6
    function automatic logic [6:0] nb(input logic [6:0] c, input logic [7:0] d);
        logic [6:0] n;
        n = c;
        n[6] = d[6];
        if (c[6]) begin
            n[5:2] = d[5:2];
            if (c[5]) n[1] = d[1];
            if (c[4]) n[0] = d[0];
        end
        return n;
    endfunction

    function automatic logic [2:0] emode(input logic [6:0] b, input logic pin, input logic fen);
        if (!pin || !fen || !b[6]) return 3'd0;
        if (b[4] && b[0]) return 3'd3;
        if (b[5] && b[1]) return 3'd5;
        if (b[4]) return 3'd2;
        if (b[5]) return 3'd4;
        if (b[2]) return 3'd6;
        if (b[3]) return 3'd7;
        return 3'd1;
    endfunction

    task automatic wr(input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
        model = nb(model, d);
    endtask

    task automatic clr();
        sw_standby = 1'b1;
        tick();
        sw_standby = 1'b0;
        model = '0;
    endtask

    task automatic check_all(input string tag);
        logic [2:0] em;
        tick();
        bus_sel = 1'b1;
        #1;
        em = emode(model, 1'b1, 1'b1);
        chk({tag, " R5 R6 rdata"}, bus_rdata, {1'b1, model});
        chk({tag, " R8 mode"}, {5'b0, mode_o}, {5'b0, em});
        chk({tag, " R9 prog_en"}, {7'b0, prog_en_o}, {7'b0, em == 3'd3});
        chk({tag, " R9 erase_en"}, {7'b0, erase_en_o}, {7'b0, em == 3'd5});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        // R1: reset with pin low
        hw_wen_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        bus_sel = 1'b1; #1;
        chk("R1 reset pin low", bus_rdata, 8'h00);
        chk("R7 mode pin low", {5'b0, mode_o}, 8'h00);
        wr(8'h40); model = '0; #1;
        chk("R4 write with pin low ignored", bus_rdata, 8'h00);

        // R1: reset with pin high
        rst_n = 1'b0; hw_wen_pin = 1'b1;
        tick();
        rst_n = 1'b1;
        tick(); #1;
        chk("R1 reset pin high", bus_rdata, 8'h80);
        chk("R8 mode after reset", {5'b0, mode_o}, 8'h00);
        chk("R9 enables after reset", {6'b0, prog_en_o, erase_en_o}, 8'h00);
        bus_sel = 1'b0; #1;
        chk("R3 unselected reads zero", bus_rdata, 8'h00);

        // R5: setup bit in same write as software enable is blocked
        wr(8'h50); #1;
        chk("R5 psu blocked with swe", bus_rdata, 8'hC0);
        // R6: program go blocked before program setup; setup still lands
        wr(8'h51); #1;
        chk("R6 partial write", bus_rdata, 8'hD0);
        check_all("program seq step");
        wr(8'h51);
        check_all("R6 program go");
        chk("R9 prog_en in program", {7'b0, prog_en_o}, 8'h01);

        // R7: pin drop forces read mode immediately, clears on edge
        hw_wen_pin = 1'b0; #1;
        chk("R7 mode read same cycle", {5'b0, mode_o}, 8'h00);
        chk("R7 prog_en off same cycle", {7'b0, prog_en_o}, 8'h00);
        tick(); #1;
        chk("R7 cleared pin low", bus_rdata, 8'h00);
        hw_wen_pin = 1'b1;
        tick(); #1;
        chk("R7 cleared after pin high", bus_rdata, 8'h80);
        model = '0;

        // R2: hardware standby wins over a simultaneous write
        wr(8'h40); wr(8'h60);
        check_all("erase setup");
        bus_wr = 1'b1; bus_wdata = 8'h62; hw_standby = 1'b1;
        tick();
        bus_wr = 1'b0; hw_standby = 1'b0; #1;
        chk("R2 hw standby clears", bus_rdata, 8'h80);
        model = '0;
        tick(); #1;
        chk("R2 mode read after standby", {5'b0, mode_o}, 8'h00);
        wr(8'h40); wr(8'h48);
        clr(); #1;
        chk("R2 sw standby clears", bus_rdata, 8'h80);

        // R3: disabled flash hides and protects contents
        wr(8'h40); wr(8'h44);
        flash_en = 1'b0; #1;
        chk("R3 disabled reads zero", bus_rdata, 8'h00);
        wr(8'h00); model = 7'h44;
        wr(8'hFF); model = 7'h44; #1;
        chk("R3 disabled still zero", bus_rdata, 8'h00);
        chk("R8 mode read while disabled", {5'b0, mode_o}, 8'h00);
        flash_en = 1'b1; #1;
        chk("R3 contents kept", bus_rdata, 8'hC4);
        check_all("R8 verify after enable");

        // R5 R6 R8: exhaustive second write after enabling
        for (int a = 0; a < 256; a++) begin
            clr();
            wr(8'h40);
            wr(a[7:0]);
            wr(8'hFF);
            check_all("sweep_a");
        end

        // R4 R5 R6 R8: scattered three-write sequences
        for (int i = 0; i < 3000; i++) begin
            clr();
            wr(8'hC0);
            wr(8'((i * 37) & 255));
            wr(8'((i * 101 + 7) & 255));
            wr(8'((i * 53 + 3) & 255));
            check_all("sweep_b");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule